// File: doc/BRIEF.md
# Transform Buffer Address Generator

This block drives the address lines of two 128 by 128 sample block buffers that sit beside a one-dimensional FFT engine. The engine transforms one line of 128 samples at a time, so a two-dimensional transform needs two passes: one over the rows and one over the columns. The engine is decimation-in-frequency and emits its results in bit-reversed index order. It does not reorder them itself. The generator undoes that scrambling on the write side, so every buffer always holds its data in natural order.

On the read side the generator walks a buffer either row after row or column after column. This lets the same engine work on rows in one pass and on columns in the next. A pass is set up by a start pulse, which captures three things: the scan direction, read or write access, and which of the two buffers is addressed. After that, each step pulse moves the generator on by one sample. The current 14-bit address is shown together with a valid flag and two markers: one for the last sample of a line and one for the last sample of the block. Stepping past the last sample of the block ends the pass and returns the generator to idle.

Top module: `xag_top`

## Requirements
- R1: After reset the generator is idle. `valid_o`, `eol_o`, `eob_o`, `we_o` and both bits of `buf_en_o` are 0.
- R2: A `start_i` pulse while idle begins a pass. From the next cycle, `valid_o` is 1 and `addr_o` is 0, the first sample of the block.
- R3: In a row read pass (`dir_col_i`=0, `write_i`=0), the address after n steps is line*128 + k. Here line = n/128 and k = n mod 128.
- R4: In a column read pass (`dir_col_i`=1, `write_i`=0), the address after n steps is k*128 + line, with line and k as in R3.
- R5: In a write pass (`write_i`=1), k is replaced by the 7-bit bit reversal of n mod 128, where bit i moves to bit 6-i. For example, 1 becomes 64 and 3 becomes 96. The row or column form of the address (R3 or R4) is otherwise kept.
- R6: The address moves on only in a cycle where `step_i` is 1 during a pass. With `step_i` at 0, `addr_o` and `valid_o` hold their values.
- R7: `eol_o` is 1 exactly while the current sample is the last of its line, that is, while n mod 128 = 127 during a pass.
- R8: `eob_o` is 1 exactly while the current sample is n = 16383. A step in that state ends the pass, and `valid_o` is 0 in the next cycle.
- R9: A `start_i` pulse during a pass is ignored. The address, the access type and the selected buffer all stay unchanged.
- R10: During a pass `buf_en_o` is one-hot. Bit 0 selects buffer 1 and bit 1 selects buffer 2, as chosen by `buf_sel_i` at start. `we_o` equals the `write_i` value captured at start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a pass when idle |
| dir_col_i | input | 1 | Scan direction: 0 row, 1 column |
| write_i | input | 1 | Access type: 0 read, 1 write (bit-reversed index) |
| buf_sel_i | input | 1 | Buffer choice: 0 buffer 1, 1 buffer 2 |
| step_i | input | 1 | Advance to the next sample |
| addr_o | output | 14 | Current buffer address |
| valid_o | output | 1 | A pass is active and addr_o is meaningful |
| we_o | output | 1 | Write strobe level for the current pass |
| buf_en_o | output | 2 | One-hot buffer enable |
| eol_o | output | 1 | Current sample is the last of a line |
| eob_o | output | 1 | Current sample is the last of the block |

## Verification
The bench probes the points where a line rolls over: the last sample of a line and the first sample of the next line, in both scan directions. A counter or transpose slip at these points would give an address off by one line or swapped between the row and column fields. Write passes are checked at indices whose bit reversal differs from the index itself. A generator that reversed the wrong field, or reversed nothing, would therefore place results at the natural address. The bench also runs a full block to the final sample, checks that the pass ends after one further step, and checks that a new pass can then begin. A start pulse sent in the middle of a pass must not restart the address, flip the access type or change the buffer.

// File: rtl/xag_pkg.sv
package xag_pkg;

    localparam int LINE_BITS_DEF = 7;
    localparam int NUM_BUFS      = 2;

    typedef enum logic {
        DIR_ROW = 1'b0,
        DIR_COL = 1'b1
    } scan_dir_e;

    typedef struct packed {
        scan_dir_e dir;
        logic      wr;
        logic      bsel;
    } pass_cfg_t;

endpackage

// File: rtl/xag_ctrl.sv
module xag_ctrl
    import xag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  pass_cfg_t cfg_i,
    input  logic      step_i,
    input  logic      last_i,
    output logic      busy_o,
    output logic      launch_o,
    output pass_cfg_t cfg_o
);

    logic finish;

    assign launch_o = start_i && !busy_o;
    assign finish   = busy_o && step_i && last_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cfg_o  <= '0;
        end else if (launch_o) begin
            busy_o <= 1'b1;
            cfg_o  <= cfg_i;
        end else if (finish) begin
            busy_o <= 1'b0;
        end
    end

    assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    assert_finish_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && step_i && last_i) |=> !busy_o);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !(step_i && last_i)) |=> (busy_o && $stable(cfg_o)));

endmodule

// File: rtl/xag_scan_cnt.sv
module xag_scan_cnt #(
    parameter int LINE_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 adv_i,
    output logic [LINE_BITS-1:0] seq_o,
    output logic [LINE_BITS-1:0] line_o,
    output logic                 eol_o,
    output logic                 eob_o
);

    localparam logic [LINE_BITS-1:0] LAST_IDX = '1;

    assign eol_o = (seq_o == LAST_IDX);
    assign eob_o = eol_o && (line_o == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            seq_o  <= '0;
            line_o <= '0;
        end else if (adv_i) begin
            seq_o <= seq_o + 1'b1;
            if (eol_o) begin
                line_o <= line_o + 1'b1;
            end
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !clear_i) |=> ($stable(seq_o) && $stable(line_o)));

    assert_line_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !clear_i && seq_o == LAST_IDX) |=>
            (seq_o == '0 && line_o == $past(line_o) + 1'b1));

endmodule

// File: rtl/xag_addr_map.sv
module xag_addr_map
    import xag_pkg::*;
#(
    parameter int LINE_BITS = 7,
    localparam int ADDR_W   = 2 * LINE_BITS
) (
    input  scan_dir_e            dir_i,
    input  logic                 wr_i,
    input  logic [LINE_BITS-1:0] seq_i,
    input  logic [LINE_BITS-1:0] line_i,
    output logic [ADDR_W-1:0]    addr_o
);

    logic [LINE_BITS-1:0] seq_rev;
    logic [LINE_BITS-1:0] k_idx;

    for (genvar b = 0; b < LINE_BITS; b++) begin : g_rev
        assign seq_rev[b] = seq_i[LINE_BITS-1-b];
    end

    assign k_idx = wr_i ? seq_rev : seq_i;

    always_comb begin
        if (dir_i == DIR_COL) begin
            addr_o = {k_idx, line_i};
        end else begin
            addr_o = {line_i, k_idx};
        end
    end

endmodule

// File: rtl/xag_top.sv
module xag_top
    import xag_pkg::*;
#(
    parameter int LINE_BITS = LINE_BITS_DEF,
    localparam int ADDR_W   = 2 * LINE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dir_col_i,
    input  logic              write_i,
    input  logic              buf_sel_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              we_o,
    output logic [1:0]        buf_en_o,
    output logic              eol_o,
    output logic              eob_o
);

    pass_cfg_t            cfg_in;
    pass_cfg_t            cfg_q;
    logic                 busy;
    logic                 launch;
    logic [LINE_BITS-1:0] seq;
    logic [LINE_BITS-1:0] line;
    logic                 cnt_eol;
    logic                 cnt_eob;

    assign cfg_in.dir  = dir_col_i ? DIR_COL : DIR_ROW;
    assign cfg_in.wr   = write_i;
    assign cfg_in.bsel = buf_sel_i;

    xag_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .cfg_i    (cfg_in),
        .step_i   (step_i),
        .last_i   (cnt_eob),
        .busy_o   (busy),
        .launch_o (launch),
        .cfg_o    (cfg_q)
    );

    xag_scan_cnt #(.LINE_BITS(LINE_BITS)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear_i (launch),
        .adv_i   (busy && step_i),
        .seq_o   (seq),
        .line_o  (line),
        .eol_o   (cnt_eol),
        .eob_o   (cnt_eob)
    );

    xag_addr_map #(.LINE_BITS(LINE_BITS)) u_map (
        .dir_i  (cfg_q.dir),
        .wr_i   (cfg_q.wr),
        .seq_i  (seq),
        .line_i (line),
        .addr_o (addr_o)
    );

    assign valid_o = busy;
    assign we_o    = busy && cfg_q.wr;
    assign eol_o   = busy && cnt_eol;
    assign eob_o   = busy && cnt_eob;

    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_en
        assign buf_en_o[b] = busy && (cfg_q.bsel == b[0]);
    end

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> (addr_o == '0));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !step_i) |=> (valid_o && $stable(addr_o)));

    assert_block_implies_line_R8: assert property (@(posedge clk) disable iff (rst)
        eob_o |-> eol_o);

    assert_buf_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $onehot(buf_en_o));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (buf_en_o == 2'b00 && !we_o && !eol_o && !eob_o));

endmodule

// File: tb/sim_xag_top.sv
module sim_xag_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, dir_col_i, write_i, buf_sel_i, step_i;
    logic [13:0] addr_o;
    logic        valid_o, we_o, eol_o, eob_o;
    logic [1:0]  buf_en_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xag_top u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_col_i(dir_col_i),
        .write_i(write_i), .buf_sel_i(buf_sel_i), .step_i(step_i),
        .addr_o(addr_o), .valid_o(valid_o), .we_o(we_o),
        .buf_en_o(buf_en_o), .eol_o(eol_o), .eob_o(eob_o)
    );

    // {col, wr, bsel, steps[13:0], exp_addr[13:0], eol, eob}
    typedef struct packed {
        logic        col;
        logic        wr;
        logic        bsel;
        logic [13:0] steps;
        logic [13:0] exp_addr;
        logic        eol;
        logic        eob;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 14'd0,     14'd0,     1'b0, 1'b0}, // R2 first addr
        '{1'b0, 1'b0, 1'b0, 14'd5,     14'd5,     1'b0, 1'b0}, // R3
        '{1'b0, 1'b0, 1'b1, 14'd130,   14'd130,   1'b0, 1'b0}, // R3 second line
        '{1'b0, 1'b0, 1'b0, 14'd127,   14'd127,   1'b1, 1'b0}, // R7 row eol
        '{1'b0, 1'b0, 1'b0, 14'd126,   14'd126,   1'b0, 1'b0}, // R7 not yet
        '{1'b1, 1'b0, 1'b0, 14'd5,     14'd640,   1'b0, 1'b0}, // R4
        '{1'b1, 1'b0, 1'b1, 14'd130,   14'd257,   1'b0, 1'b0}, // R4
        '{1'b1, 1'b0, 1'b0, 14'd127,   14'd16256, 1'b1, 1'b0}, // R4 R7
        '{1'b0, 1'b1, 1'b1, 14'd1,     14'd64,    1'b0, 1'b0}, // R5 row
        '{1'b0, 1'b1, 1'b0, 14'd131,   14'd224,   1'b0, 1'b0}, // R5 row
        '{1'b1, 1'b1, 1'b0, 14'd1,     14'd8192,  1'b0, 1'b0}, // R5 col
        '{1'b1, 1'b1, 1'b1, 14'd6,     14'd6144,  1'b0, 1'b0}, // R5 col
        '{1'b1, 1'b1, 1'b0, 14'd129,   14'd8193,  1'b0, 1'b0}, // R5 col
        '{1'b0, 1'b1, 1'b1, 14'd16383, 14'd16383, 1'b1, 1'b1}  // R8 last
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0; step_i = 1'b0;
        dir_col_i = 1'b0; write_i = 1'b0; buf_sel_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic launch(input logic col, input logic wr, input logic bsel);
        dir_col_i = col; write_i = wr; buf_sel_i = bsel; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic steps(input int n);
        if (n > 0) begin
            step_i = 1'b1;
            repeat (n) @(negedge clk);
            step_i = 1'b0;
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(valid_o == 1'b0, "R1 valid", valid_o, 0);
        check(buf_en_o == 2'b00 && !we_o, "R1 enables", buf_en_o, 0);
        check(!eol_o && !eob_o, "R1 markers", {eol_o, eob_o}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            do_reset();
            launch(VECS[i].col, VECS[i].wr, VECS[i].bsel);
            check(valid_o == 1'b1, "R2 valid after start", valid_o, 1);
            steps(int'(VECS[i].steps));
            check(addr_o == VECS[i].exp_addr, "R3/R4/R5 address",
                  addr_o, VECS[i].exp_addr);
            check(eol_o == VECS[i].eol, "R7 eol", eol_o, VECS[i].eol);
            check(eob_o == VECS[i].eob, "R8 eob", eob_o, VECS[i].eob);
            check(buf_en_o == (VECS[i].bsel ? 2'b10 : 2'b01), "R10 buf_en",
                  buf_en_o, VECS[i].bsel ? 2 : 1);
            check(we_o == VECS[i].wr, "R10 we", we_o, VECS[i].wr);
        end

        // R8: a step at the last sample ends the pass (continues from last vector)
        steps(1);
        check(valid_o == 1'b0, "R8 idle after block", valid_o, 0);
        check(buf_en_o == 2'b00, "R8 enables drop", buf_en_o, 0);
        // restart works after completion
        launch(1'b1, 1'b0, 1'b0);
        check(valid_o && addr_o == 14'd0, "R2 restart", addr_o, 0);
        steps(2);
        check(addr_o == 14'd256, "R4 after restart", addr_o, 256);

        // R6: no step, address holds
        do_reset();
        launch(1'b0, 1'b0, 1'b0);
        steps(3);
        repeat (5) @(negedge clk);
        check(addr_o == 14'd3 && valid_o, "R6 hold", addr_o, 3);

        // R9: start during a pass is ignored
        launch(1'b1, 1'b1, 1'b1);
        check(addr_o == 14'd3, "R9 address kept", addr_o, 3);
        check(we_o == 1'b0, "R9 access kept", we_o, 0);
        check(buf_en_o == 2'b01, "R9 buffer kept", buf_en_o, 1);
        steps(1);
        check(addr_o == 14'd4, "R9 row scan continues", addr_o, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule